// File: doc/BRIEF.md
# SPI NOR Flash Command Engine

This block behaves as the slave end of a serial NOR flash. A host drives chip select (active low), a serial clock and a data line in SPI mode 0, and reads answers on the return data line. Each chip-select frame carries one opcode, then any address bytes and data bytes. The block supports identification, streaming read, page program, sector erase, whole-array erase, write enable, entry into 4-byte addressing and a two-frame reset. The storage is a small internal byte array, sized by parameter so that a simulation can hold it.

The serial inputs are sampled by a faster system clock. A rising serial clock edge shifts in one command bit, MSB first. A falling edge shifts out the next answer bit. Commands that change state take effect when chip select returns high. The one exception is program data: each program byte is merged into the array as soon as its eighth bit arrives.

Top module: `spi_nor_engine`

## Requirements
- R1: Opcode 0x9F answers with the three bytes 0x20, 0xBA, 0x19, in that order, in the three byte slots that follow the opcode.
- R2: After reset every array byte reads 0x00, addressing uses 3 bytes, write enable is clear and the return line is low.
- R3: Opcode 0x03, followed by an address sent MSB first, returns the byte at that address and then the bytes at the following addresses for as long as chip select stays low. The address wraps from the last byte of the array to byte 0.
- R4: Opcode 0x02, followed by an address, ANDs each later data byte into the stored byte. The address advances only within its 256-byte page and wraps to the start of that page.
- R5: Program (0x02), sector erase (0xD8) and array erase (0xC7) change nothing unless a frame holding opcode 0x06 ended earlier and no program or erase frame has ended since.
- R6: Opcode 0xD8, followed by an address, sets to 0xFF every byte of the 512-byte sector that holds the address, at the end of the frame. Bytes outside that sector, including the page just before it, are unchanged.
- R7: Write enable clears at the end of any frame whose opcode is 0x02, 0xD8 or 0xC7.
- R8: After a frame holding opcode 0xB7, every address is 4 bytes long. Address bits above the array size are ignored.
- R9: A frame holding opcode 0x99 that directly follows a frame holding opcode 0x66 returns the block to 3-byte addressing and clears write enable.
- R10: A frame holding opcode 0x99 whose previous frame held any opcode other than 0x66 has no effect.
- R11: Opcode 0xC7 sets every byte of the array to 0xFF at the end of the frame.
- R12: The return line is low while chip select is high, changes only after a falling serial clock edge, and sends each byte MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low; one command per frame |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The system clock sees a serial edge one cycle after the pin changes. The return line therefore moves one system clock after a falling serial clock edge. The bench holds each serial half period for four system clocks and samples the return line just before it raises the serial clock. This keeps the sample three cycles clear of the update.

Commands that change state act in the cycle after chip select rises. The bench waits six cycles after raising chip select before it starts the next frame, and it checks that effect through the read data of a later frame. Idle behaviour of the return line is compared on every system clock while chip select has been high for two samples.

// File: rtl/spi_nor_engine.sv
module spi_nor_engine #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 9,
  parameter logic [23:0] ID_CODE = 24'h20BA19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] OP_ID = 8'h9F, OP_RD = 8'h03, OP_PP = 8'h02, OP_SE = 8'hD8,
                         OP_BE = 8'hC7, OP_WE = 8'h06, OP_4B = 8'hB7, OP_RA = 8'h66,
                         OP_RS = 8'h99;

  logic sck_q, cs_q, wel, four_b, armed;
  logic [2:0] bitcnt, bytecnt;
  logic [6:0] rx_sr;
  logic [7:0] opcode, tx_sr, next_tx;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [DEPTH];

  wire sck_rise  = sck & ~sck_q & ~cs_n;
  wire sck_fall  = ~sck & sck_q & ~cs_n;
  wire cs_rise   = cs_n & ~cs_q;
  wire [7:0] byte_in = {rx_sr, mosi};
  wire byte_done = sck_rise && bitcnt == 3'd7;
  wire [2:0] alen = four_b ? 3'd4 : 3'd3;
  wire have_op   = bytecnt != 3'd0;
  wire in_addr   = have_op && bytecnt <= alen;
  wire in_data   = bytecnt > alen;
  wire do_bulk   = cs_rise && wel && have_op && opcode == OP_BE;
  wire do_sect   = cs_rise && wel && in_data && opcode == OP_SE;

  assign miso = tx_sr[7];

  always_comb begin
    next_tx = 8'h00;
    if (opcode == OP_ID) begin
      case (bytecnt)
        3'd1: next_tx = ID_CODE[23:16];
        3'd2: next_tx = ID_CODE[15:8];
        3'd3: next_tx = ID_CODE[7:0];
        default: next_tx = 8'h00;
      endcase
    end else if (opcode == OP_RD && in_data) begin
      next_tx = mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; bitcnt <= '0; bytecnt <= '0;
      rx_sr <= '0; opcode <= '0; tx_sr <= '0; addr <= '0;
      wel <= 1'b0; four_b <= 1'b0; armed <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bitcnt <= '0; bytecnt <= '0; tx_sr <= '0; addr <= '0;
      end else begin
        if (sck_rise) begin
          rx_sr  <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          if (bytecnt != 3'd6) bytecnt <= bytecnt + 3'd1;
          if (!have_op) opcode <= byte_in;
          else if (in_addr) addr <= {addr[ADDR_W-9:0], byte_in};
          else if (opcode == OP_RD) addr <= addr + 1'b1;
          else if (opcode == OP_PP) addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
        end
        if (sck_fall) tx_sr <= (bitcnt == 3'd0) ? next_tx : {tx_sr[6:0], 1'b0};
      end
      if (cs_rise && have_op) begin
        armed <= opcode == OP_RA;
        case (opcode)
          OP_WE: wel <= 1'b1;
          OP_4B: four_b <= 1'b1;
          OP_RS: if (armed) begin four_b <= 1'b0; wel <= 1'b0; end
          OP_PP, OP_SE, OP_BE: wel <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (byte_done && opcode == OP_PP && in_data && wel) mem[addr] <= mem[addr] & byte_in;
      if (do_bulk || do_sect) begin
        for (int i = 0; i < DEPTH; i++)
          if (do_bulk || (ADDR_W'(i) >> SECT_W) == (addr >> SECT_W)) mem[i] <= 8'hFF;
      end
    end
  end
endmodule

module spi_nor_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic miso,
  input logic cs_rise,
  input logic have_op,
  input logic [7:0] opcode,
  input logic wel,
  input logic four_b,
  input logic armed
);
  // R12
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !miso);
  // R12
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck && $past(sck) && !cs_n && $past(!cs_n) |-> $stable(miso));
  // R7
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && have_op && (opcode == 8'h02 || opcode == 8'hD8 || opcode == 8'hC7) |=> !wel);
  // R8
  four_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && have_op && opcode == 8'hB7 |=> four_b);
  // R9
  reset_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && have_op && opcode == 8'h99 && armed |=> !four_b && !wel);
  // R10
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && have_op && opcode != 8'h66 |=> !armed);
endmodule

bind spi_nor_engine spi_nor_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .miso(miso),
  .cs_rise(cs_rise), .have_op(have_op), .opcode(opcode),
  .wel(wel), .four_b(four_b), .armed(armed)
);

// File: tb/sim_spi_nor_engine.sv
module sim_spi_nor_engine;
  localparam int DEPTH = 2048;
  localparam int MASK = DEPTH - 1;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] ref_mem [DEPTH];
  bit m_wel = 0, m_4b = 0, m_arm = 0;
  logic cs_prev = 1'b1;

  spi_nor_engine u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // R12: return line low whenever chip select has stayed high
  always @(negedge clk) begin
    if (rst_n && !done && cs_n && cs_prev) chk("R12 idle", {7'd0, miso}, 8'h00);
    cs_prev <= cs_n;
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (4) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_addr(input logic [31:0] a);
    logic [7:0] r;
    if (m_4b) xfer(a[31:24], r);
    xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    open_frame(); xfer(op, r); close_frame();
    case (op)
      8'h06: m_wel = 1;
      8'hB7: m_4b = 1;
      8'h99: if (m_arm) begin m_4b = 0; m_wel = 0; end
      default: ;
    endcase
    m_arm = (op == 8'h66);
  endtask

  task automatic do_id();
    logic [7:0] r;
    open_frame(); xfer(8'h9F, r);
    xfer(8'h00, r); chk("R1 id0", r, 8'h20);
    xfer(8'h00, r); chk("R1 id1", r, 8'hBA);
    xfer(8'h00, r); chk("R1 id2", r, 8'h19);
    close_frame();
    m_arm = 0;
  endtask

  task automatic do_read(input string tag, input logic [31:0] a, input int n);
    logic [7:0] r;
    open_frame(); xfer(8'h03, r); send_addr(a);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      chk(tag, r, ref_mem[(int'(a[10:0]) + i) & MASK]);
    end
    close_frame();
    m_arm = 0;
  endtask

  task automatic do_prog(input logic [31:0] a, input logic [7:0] d [$]);
    logic [7:0] r;
    open_frame(); xfer(8'h02, r); send_addr(a);
    foreach (d[i]) xfer(d[i], r);
    close_frame();
    if (m_wel)
      foreach (d[i]) begin
        int idx;
        idx = (int'(a[10:8]) << 8) | ((int'(a[7:0]) + i) & 255);
        ref_mem[idx] = ref_mem[idx] & d[i];
      end
    m_wel = 0; m_arm = 0;
  endtask

  task automatic do_erase(input logic [31:0] a);
    logic [7:0] r;
    open_frame(); xfer(8'hD8, r); send_addr(a); close_frame();
    if (m_wel)
      for (int i = 0; i < DEPTH; i++) if ((i >> 9) == int'(a[10:9])) ref_mem[i] = 8'hFF;
    m_wel = 0; m_arm = 0;
  endtask

  task automatic do_bulk();
    logic [7:0] r;
    open_frame(); xfer(8'hC7, r); close_frame();
    if (m_wel) for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    m_wel = 0; m_arm = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] dq [$];
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 miso after reset", {7'd0, miso}, 8'h00);

    do_id();
    do_read("R2 zero array", 32'h0000_0000, 8);

    dq = '{8'h00, 8'h00};
    do_prog(32'h0000_0010, dq);
    do_read("R5 program without enable", 32'h0000_0010, 2);
    do_erase(32'h0000_0000);
    do_read("R5 erase without enable", 32'h0000_0000, 4);

    cmd1(8'h06);
    do_erase(32'h0000_0205);
    do_read("R6 sector and previous page", 32'h0000_01F8, 16);
    do_read("R6 sector end and next", 32'h0000_03FC, 8);

    cmd1(8'h06);
    dq = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'h5A, 8'h3C, 8'h0F, 8'hF0};
    do_prog(32'h0000_02FC, dq);
    do_read("R4 page wrap end", 32'h0000_02FA, 6);
    do_read("R4 page wrap start", 32'h0000_0200, 4);

    dq = '{8'h00, 8'h00};
    do_prog(32'h0000_02FC, dq);
    do_read("R7 enable cleared after program", 32'h0000_02FC, 2);

    cmd1(8'h06);
    dq = '{8'hF0, 8'h33};
    do_prog(32'h0000_0202, dq);
    do_read("R4 and merge", 32'h0000_0200, 4);

    do_read("R3 array wrap", 32'h0000_07FE, 4);

    cmd1(8'hB7);
    do_read("R8 four byte address", 32'h1234_02FC, 6);

    cmd1(8'h66);
    do_id();
    cmd1(8'h99);
    do_read("R10 unpaired reset", 32'h0000_0200, 3);

    cmd1(8'h06);
    cmd1(8'h66);
    cmd1(8'h99);
    do_read("R9 three byte after reset", 32'h0000_02FC, 4);
    dq = '{8'h00};
    do_prog(32'h0000_0200, dq);
    do_read("R9 enable cleared by reset", 32'h0000_0200, 2);

    do_bulk();
    do_read("R5 bulk without enable", 32'h0000_0000, 2);
    cmd1(8'h06);
    do_bulk();
    do_read("R11 bulk low", 32'h0000_0000, 4);
    do_read("R11 bulk high", 32'h0000_07F8, 8);
    do_read("R11 bulk mid", 32'h0000_01FC, 8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule